// File: doc/BRIEF.md
# Tiled Two-Lane Inverse 5/3 Wavelet Reconstructor

This block rebuilds one square tile of pixels from a single level of 5/3 wavelet subbands. Coefficients stream in one per cycle through a valid/ready port. The four subband values of a location arrive as a group, and the locations arrive row by row over the quarter-size subband grid. Once the tile is stored, the block runs two inverse lifting passes. Two column processors undo the vertical split for a pair of subband columns per run. Two row processors then undo the horizontal split for a pair of pixel rows at once.

Each output beat carries four pixels: a 2x2 square with the coordinate of its upper-left pixel. The beats appear in a fixed raster order of squares. The number of cycles from the last input to the first output is fixed, and so is the number of cycles until the input reopens. Software or a downstream stage can therefore schedule tiles back to back without a handshake on the output.

Top module: `inverseDwtTile`

## Requirements
- R1: After reset, inReady is 1 and outValid is 0.
- R2: A tile has W*H coefficients. Each is accepted in a cycle where inValid and inReady are both 1. Within one subband location the order is LL, LH, HL, HH (band codes 0 to 3). Locations run with the subband column index fastest, then the subband row index. The subband grid is W/2 wide and H/2 tall.
- R3: inReady drops only in the cycle after a coefficient is accepted. It stays 0 for exactly W*H/8 + W*H/4 cycles after the last coefficient of a tile is accepted, then returns to 1.
- R4: The first outValid of a tile appears W*H/8 + 2 cycles after the cycle in which its last coefficient was accepted. At the default 8x8 tile this is 10 cycles.
- R5: outValid stays high for exactly W*H/4 consecutive cycles. The beats are ordered by outX = 0, 2, ..., W-2 within outY = 0, 2, ..., H-2. The first beat is at (0,0).
- R6: The pixel at row y and column x equals the separable integer inverse 5/3 transform: a vertical pass first, then a horizontal pass, all divisions rounding toward minus infinity. In each 1-D pass, with low s and high d, even[k] = s[k] - floor((d[k-1]+d[k]+2)/4) and odd[k] = d[k] + floor((even[k]+even[k+1])/2). The vertical pass turns LL/LH into the low row set and HL/HH into the high row set. outPix00 is (y,x), outPix01 is (y,x+1), outPix10 is (y+1,x) and outPix11 is (y+1,x+1).
- R7: At tile edges the block mirrors its inputs. A missing d[-1] is taken as d[0]. A missing even[n] past the end is taken as the last even value.
- R8: A tile started in the cycle where inReady returns gives results that do not depend on the previous tile.
- R9: inValid is ignored while inReady is 0. Junk presented then does not alter the tile being processed.
- R10: Reset during a partly loaded tile discards it. The next full tile is reconstructed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Coefficient on inCoef is offered |
| inCoef | input | DW | Signed subband coefficient |
| inReady | output | 1 | Block is loading and takes a coefficient this cycle |
| outValid | output | 1 | A 2x2 pixel square is on the outputs |
| outX | output | log2(W) | Column of the square's left pixels |
| outY | output | log2(H) | Row of the square's upper pixels |
| outPix00 | output | DW | Pixel (outY, outX) |
| outPix01 | output | DW | Pixel (outY, outX+1) |
| outPix10 | output | DW | Pixel (outY+1, outX) |
| outPix11 | output | DW | Pixel (outY+1, outX+1) |

## Verification
The bench builds the block with its defaults: an 8x8 tile and 16-bit words. This gives a 4x4 subband grid with two column-pair runs, so each processor lane meets an interior position and both mirrored edges. The second run of column processors also writes a separate half of the intermediate store. Tiles with edge-only energy, hashed values and a band-distinct ramp bring the mirror rules and the input ordering into reach. Back-to-back tiles, junk while busy, and a reset mid-load cover the timing and the discard rules.

// File: rtl/dwtTilePkg.sv
package dwtTilePkg;
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_COL  = 2'd1,
    PH_ROW  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    BAND_LL = 2'd0,
    BAND_LH = 2'd1,
    BAND_HL = 2'd2,
    BAND_HH = 2'd3
  } band_e;

  typedef struct packed {
    logic loadEn;
    logic colEn;
    logic rowEn;
  } strobe_t;
endpackage

// File: rtl/lift53Pair.sv
// One inverse 5/3 lifting window: yields the even/odd pair at index k.
module lift53Pair #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] sCur,
  input  logic signed [DW-1:0] sNext,
  input  logic signed [DW-1:0] dPrev,
  input  logic signed [DW-1:0] dCur,
  input  logic signed [DW-1:0] dNext,
  input  logic                 atEnd,
  output logic signed [DW-1:0] xEven,
  output logic signed [DW-1:0] xOdd
);
  localparam int EW = DW + 3;

  logic signed [EW-1:0] sC, sN, dP, dC, dN;
  logic signed [EW-1:0] evHere, evAhead, pairSum, odd;

  always_comb begin
    sC = EW'(sCur);
    sN = EW'(sNext);
    dP = EW'(dPrev);
    dC = EW'(dCur);
    dN = EW'(dNext);
    evHere  = sC - ((dP + dC + EW'(2)) >>> 2);
    evAhead = sN - ((dC + dN + EW'(2)) >>> 2);
    pairSum = atEnd ? (evHere + evHere) : (evHere + evAhead);
    odd     = dC + (pairSum >>> 1);
    xEven   = DW'(evHere);
    xOdd    = DW'(odd);
  end
endmodule

// File: rtl/dwtTileCtrl.sv
module dwtTileCtrl
  import dwtTilePkg::*;
#(
  parameter int W = 8,
  parameter int H = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  output strobe_t       strobe,
  output logic [1:0]    ldBand,
  output logic [$clog2(H/2)-1:0] ldRow,
  output logic [$clog2(W/2)-1:0] ldCol,
  output logic [((W/4) > 1 ? $clog2(W/4) : 1)-1:0] colPair,
  output logic [$clog2(H/2)-1:0] colK,
  output logic [$clog2(H/2)-1:0] rowQ,
  output logic [$clog2(W/2)-1:0] rowK
);
  localparam int SW = W / 2;
  localparam int SH = H / 2;
  localparam int NP = W / 4;
  localparam int JW = $clog2(SW);
  localparam int KW = $clog2(SH);
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;
  localparam logic [JW-1:0] LAST_J = JW'(SW - 1);
  localparam logic [KW-1:0] LAST_K = KW'(SH - 1);
  localparam logic [PW-1:0] LAST_P = PW'(NP - 1);

  phase_e phase;

  always_comb begin
    inReady       = (phase == PH_LOAD);
    strobe.loadEn = inReady & inValid;
    strobe.colEn  = (phase == PH_COL);
    strobe.rowEn  = (phase == PH_ROW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_LOAD;
      ldBand  <= '0;
      ldRow   <= '0;
      ldCol   <= '0;
      colPair <= '0;
      colK    <= '0;
      rowQ    <= '0;
      rowK    <= '0;
    end else begin
      unique case (phase)
        PH_LOAD: begin
          if (inValid) begin
            ldBand <= ldBand + 2'd1;
            if (ldBand == BAND_HH) begin
              if (ldCol == LAST_J) begin
                ldCol <= '0;
                if (ldRow == LAST_K) begin
                  ldRow <= '0;
                  phase <= PH_COL;
                end else begin
                  ldRow <= ldRow + 1'b1;
                end
              end else begin
                ldCol <= ldCol + 1'b1;
              end
            end
          end
        end
        PH_COL: begin
          if (colK == LAST_K) begin
            colK <= '0;
            if (colPair == LAST_P) begin
              colPair <= '0;
              phase   <= PH_ROW;
            end else begin
              colPair <= colPair + 1'b1;
            end
          end else begin
            colK <= colK + 1'b1;
          end
        end
        PH_ROW: begin
          if (rowK == LAST_J) begin
            rowK <= '0;
            if (rowQ == LAST_K) begin
              rowQ  <= '0;
              phase <= PH_LOAD;
            end else begin
              rowQ <= rowQ + 1'b1;
            end
          end else begin
            rowK <= rowK + 1'b1;
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/dwtTileDatapath.sv
module dwtTileDatapath
  import dwtTilePkg::*;
#(
  parameter int W  = 8,
  parameter int H  = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic signed [DW-1:0] inCoef,
  input  logic [1:0]           ldBand,
  input  logic [$clog2(H/2)-1:0] ldRow,
  input  logic [$clog2(W/2)-1:0] ldCol,
  input  logic [((W/4) > 1 ? $clog2(W/4) : 1)-1:0] colPair,
  input  logic [$clog2(H/2)-1:0] colK,
  input  logic [$clog2(H/2)-1:0] rowQ,
  input  logic [$clog2(W/2)-1:0] rowK,
  output logic                 outValid,
  output logic [$clog2(W)-1:0] outX,
  output logic [$clog2(H)-1:0] outY,
  output logic signed [DW-1:0] outPix00,
  output logic signed [DW-1:0] outPix01,
  output logic signed [DW-1:0] outPix10,
  output logic signed [DW-1:0] outPix11
);
  localparam int SW = W / 2;
  localparam int SH = H / 2;
  localparam int JW = $clog2(SW);
  localparam int KW = $clog2(SH);
  localparam int YW = $clog2(H);
  localparam logic [JW-1:0] LAST_J = JW'(SW - 1);
  localparam logic [KW-1:0] LAST_K = KW'(SH - 1);

  typedef logic signed [DW-1:0] word_t;

  word_t coefMem [4][SH][SW];
  word_t lowBuf  [H][SW];
  word_t highBuf [H][SW];

  // Column lanes: index = lane*2 + half (half 0 -> low rows, 1 -> high rows)
  word_t colEven [4];
  word_t colOdd  [4];
  word_t rowEven [2];
  word_t rowOdd  [2];

  logic [JW-1:0] jIdx [2];
  logic [YW-1:0] yIdx [2];
  logic [KW-1:0] kPrev, kNext;
  logic [JW-1:0] jPrev, jNext;

  always_comb begin
    jIdx[0] = JW'({colPair, 1'b0});
    jIdx[1] = JW'({colPair, 1'b1});
    yIdx[0] = {rowQ, 1'b0};
    yIdx[1] = {rowQ, 1'b1};
    kPrev   = (colK == '0)    ? colK : colK - 1'b1;
    kNext   = (colK == LAST_K) ? colK : colK + 1'b1;
    jPrev   = (rowK == '0)    ? rowK : rowK - 1'b1;
    jNext   = (rowK == LAST_J) ? rowK : rowK + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.loadEn) coefMem[ldBand][ldRow][ldCol] <= inCoef;
  end

  for (genvar c = 0; c < 2; c++) begin : g_colProc
    for (genvar g = 0; g < 2; g++) begin : g_half
      localparam logic [1:0] S_BAND = 2'(2 * g);
      localparam logic [1:0] D_BAND = 2'(2 * g + 1);
      lift53Pair #(.DW(DW)) u_lift (
        .sCur (coefMem[S_BAND][colK][jIdx[c]]),
        .sNext(coefMem[S_BAND][kNext][jIdx[c]]),
        .dPrev(coefMem[D_BAND][kPrev][jIdx[c]]),
        .dCur (coefMem[D_BAND][colK][jIdx[c]]),
        .dNext(coefMem[D_BAND][kNext][jIdx[c]]),
        .atEnd(colK == LAST_K),
        .xEven(colEven[c*2+g]),
        .xOdd (colOdd[c*2+g])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.colEn) begin
      for (int c = 0; c < 2; c++) begin
        lowBuf [{colK, 1'b0}][jIdx[c]] <= colEven[c*2];
        lowBuf [{colK, 1'b1}][jIdx[c]] <= colOdd[c*2];
        highBuf[{colK, 1'b0}][jIdx[c]] <= colEven[c*2+1];
        highBuf[{colK, 1'b1}][jIdx[c]] <= colOdd[c*2+1];
      end
    end
  end

  for (genvar r = 0; r < 2; r++) begin : g_rowProc
    lift53Pair #(.DW(DW)) u_lift (
      .sCur (lowBuf[yIdx[r]][rowK]),
      .sNext(lowBuf[yIdx[r]][jNext]),
      .dPrev(highBuf[yIdx[r]][jPrev]),
      .dCur (highBuf[yIdx[r]][rowK]),
      .dNext(highBuf[yIdx[r]][jNext]),
      .atEnd(rowK == LAST_J),
      .xEven(rowEven[r]),
      .xOdd (rowOdd[r])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outX     <= '0;
      outY     <= '0;
      outPix00 <= '0;
      outPix01 <= '0;
      outPix10 <= '0;
      outPix11 <= '0;
    end else begin
      outValid <= strobe.rowEn;
      if (strobe.rowEn) begin
        outX     <= {rowK, 1'b0};
        outY     <= {rowQ, 1'b0};
        outPix00 <= rowEven[0];
        outPix01 <= rowOdd[0];
        outPix10 <= rowEven[1];
        outPix11 <= rowOdd[1];
      end
    end
  end
endmodule

// File: rtl/inverseDwtTile.sv
module inverseDwtTile
  import dwtTilePkg::*;
#(
  parameter int W  = 8,
  parameter int H  = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inCoef,
  output logic                 inReady,
  output logic                 outValid,
  output logic [$clog2(W)-1:0] outX,
  output logic [$clog2(H)-1:0] outY,
  output logic signed [DW-1:0] outPix00,
  output logic signed [DW-1:0] outPix01,
  output logic signed [DW-1:0] outPix10,
  output logic signed [DW-1:0] outPix11
);
  localparam int JW = $clog2(W / 2);
  localparam int KW = $clog2(H / 2);
  localparam int PW = ((W / 4) > 1) ? $clog2(W / 4) : 1;

  strobe_t       strobe;
  logic [1:0]    ldBand;
  logic [KW-1:0] ldRow, colK, rowQ;
  logic [JW-1:0] ldCol, rowK;
  logic [PW-1:0] colPair;

  dwtTileCtrl #(.W(W), .H(H)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .strobe(strobe), .ldBand(ldBand), .ldRow(ldRow), .ldCol(ldCol),
    .colPair(colPair), .colK(colK), .rowQ(rowQ), .rowK(rowK)
  );

  dwtTileDatapath #(.W(W), .H(H), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inCoef(inCoef),
    .ldBand(ldBand), .ldRow(ldRow), .ldCol(ldCol),
    .colPair(colPair), .colK(colK), .rowQ(rowQ), .rowK(rowK),
    .outValid(outValid), .outX(outX), .outY(outY),
    .outPix00(outPix00), .outPix01(outPix01),
    .outPix10(outPix10), .outPix11(outPix11)
  );
endmodule

// File: rtl/dwtTileChecker.sv
module dwtTileChecker #(
  parameter int W = 8,
  parameter int H = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 inReady,
  input logic                 outValid,
  input logic [$clog2(W)-1:0] outX,
  input logic [$clog2(H)-1:0] outY
);
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);
  localparam logic [15:0] FIRST_GAP = 16'(W * H / 8 + 1);
  localparam logic [15:0] BEATS     = 16'(W * H / 4);

  logic [15:0] busyCnt;
  logic [15:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      runCnt  <= '0;
    end else begin
      busyCnt <= inReady ? 16'd0 : busyCnt + 16'd1;
      runCnt  <= outValid ? runCnt + 16'd1 : 16'd0;
    end
  end

  assert_ready_falls_on_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inReady) |-> $past(inValid));

  assert_quiet_while_loading_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && $past(inReady)) |-> !outValid);

  assert_first_beat_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (busyCnt == FIRST_GAP));

  assert_first_beat_origin_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outX == '0 && outY == '0));

  assert_column_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && outX != '0) |->
      (outX == $past(outX) + XW'(2) && outY == $past(outY)));

  assert_row_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && outX == '0) |-> (outY == $past(outY) + YW'(2)));

  assert_beat_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> (runCnt == BEATS));
endmodule

bind inverseDwtTile dwtTileChecker #(.W(W), .H(H)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outX(outX), .outY(outY)
);

// File: tb/tb_inverseDwtTile.sv
module tb_inverseDwtTile;
  localparam int W  = 8;
  localparam int H  = 8;
  localparam int DW = 16;
  localparam int SW = W / 2;
  localparam int SH = H / 2;
  localparam int C  = W * H / 8;
  localparam int R  = W * H / 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rstN;
  logic                 inValid;
  logic signed [DW-1:0] inCoef;
  logic                 inReady;
  logic                 outValid;
  logic [$clog2(W)-1:0] outX;
  logic [$clog2(H)-1:0] outY;
  logic signed [DW-1:0] outPix00, outPix01, outPix10, outPix11;

  inverseDwtTile #(.W(W), .H(H), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCoef(inCoef),
    .inReady(inReady), .outValid(outValid), .outX(outX), .outY(outY),
    .outPix00(outPix00), .outPix01(outPix01),
    .outPix10(outPix10), .outPix11(outPix11)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  int coefT  [4][SH][SW];
  int midT   [2][H][SW];
  int pixRef [H][W];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int coefVal(input int pat, input int b, input int i, input int j);
    int h;
    if (pat == 0) return b * 40 + i * 6 + j * 3 - 50;
    if (pat == 2) begin
      if (i == 0 || i == SH - 1 || j == 0 || j == SW - 1)
        return ((b + 1) * (i * SW + j + 1) * 3) % 121 - 60;
      return 0;
    end
    h = b * 53 + i * 29 + j * 19 + pat * 11;
    return ((h * h + 7 * h) % 199) - 99;
  endfunction

  // Whole-vector inverse lifting with mirrored ends.
  task automatic lift1d(input int s[16], input int d[16], input int n,
                        output int e[16], output int o[16]);
    for (int k = 0; k < n; k++)
      e[k] = s[k] - ((d[(k == 0) ? 0 : k - 1] + d[k] + 2) >>> 2);
    for (int k = 0; k < n; k++)
      o[k] = d[k] + ((e[k] + e[(k == n - 1) ? k : k + 1]) >>> 1);
  endtask

  task automatic buildRef(input int pat);
    int s[16], d[16], e[16], o[16];
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < SH; i++)
        for (int j = 0; j < SW; j++)
          coefT[b][i][j] = coefVal(pat, b, i, j);
    for (int j = 0; j < SW; j++)
      for (int g = 0; g < 2; g++) begin
        for (int k = 0; k < SH; k++) begin
          s[k] = coefT[2*g][k][j];
          d[k] = coefT[2*g+1][k][j];
        end
        lift1d(s, d, SH, e, o);
        for (int k = 0; k < SH; k++) begin
          midT[g][2*k][j]   = e[k];
          midT[g][2*k+1][j] = o[k];
        end
      end
    for (int y = 0; y < H; y++) begin
      for (int k = 0; k < SW; k++) begin
        s[k] = midT[0][y][k];
        d[k] = midT[1][y][k];
      end
      lift1d(s, d, SW, e, o);
      for (int k = 0; k < SW; k++) begin
        pixRef[y][2*k]   = e[k];
        pixRef[y][2*k+1] = o[k];
      end
    end
  endtask

  // Loads one tile, then watches the busy window; caller sits at a negedge.
  task automatic runTile(input int pat, input bit gaps, input bit junk, input string req);
    int firstT, beat, ex, ey;
    string pr;
    buildRef(pat);
    for (int i = 0; i < SH; i++)
      for (int j = 0; j < SW; j++)
        for (int b = 0; b < 4; b++) begin
          if (gaps && ((i + j + b) % 3 == 0)) begin
            inValid = 1'b0;
            @(negedge clk);
          end
          inValid = 1'b1;
          inCoef  = DW'(coefT[b][i][j]);
          @(negedge clk);
        end
    inValid = 1'b0;
    firstT = -1;
    beat = 0;
    for (int t = 1; t <= C + R + 1; t++) begin
      if (junk) begin
        inValid = (t <= C + R);
        inCoef  = 16'sh5A5A;
      end
      chk(inReady == (t == C + R + 1), "R3", "inReady in busy window",
          int'(inReady), int'(t == C + R + 1));
      if (outValid) begin
        if (firstT < 0) firstT = t;
        ey = 2 * (beat / SW);
        ex = 2 * (beat % SW);
        chk(int'(outX) == ex, "R5", "outX", int'(outX), ex);
        chk(int'(outY) == ey, "R5", "outY", int'(outY), ey);
        pr = (ex == 0 || ey == 0 || ex == W - 2 || ey == H - 2) && pat == 2 ? "R7" : req;
        chk(int'(outPix00) == pixRef[ey][ex],     pr, "pix00", int'(outPix00), pixRef[ey][ex]);
        chk(int'(outPix01) == pixRef[ey][ex+1],   pr, "pix01", int'(outPix01), pixRef[ey][ex+1]);
        chk(int'(outPix10) == pixRef[ey+1][ex],   pr, "pix10", int'(outPix10), pixRef[ey+1][ex]);
        chk(int'(outPix11) == pixRef[ey+1][ex+1], pr, "pix11", int'(outPix11), pixRef[ey+1][ex+1]);
        beat++;
      end
      @(negedge clk);
    end
    inValid = 1'b0;
    chk(firstT == C + 2, "R4", "first beat cycle", firstT, C + 2);
    chk(beat == R, "R5", "beat count", beat, R);
    chk(!outValid, "R5", "outValid after window", int'(outValid), 0);
  endtask

  task automatic testResetState();
    chk(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    chk(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
  endtask

  task automatic testMidLoadReset();
    for (int n = 0; n < 13; n++) begin
      inValid = 1'b1;
      inCoef  = DW'(n * 7 - 40);
      @(negedge clk);
    end
    inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(inReady == 1'b1, "R10", "inReady in reset", int'(inReady), 1);
    chk(outValid == 1'b0, "R10", "outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    runTile(5, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    rstN = 1'b0;
    inValid = 1'b0;
    inCoef = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    runTile(0, 1'b0, 1'b0, "R2");
    runTile(1, 1'b1, 1'b0, "R6");
    runTile(2, 1'b0, 1'b0, "R6");
    runTile(3, 1'b0, 1'b0, "R8");
    runTile(4, 1'b0, 1'b1, "R9");
    testMidLoadReset();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule